// File: doc/BRIEF.md
# Parallel Write Checksum with Bus-Inversion Correction

This block prepares one write burst for an eight-bit double-data-rate memory lane. A burst has eight beats of eight data bits and one active-low inversion flag per beat. The block takes the 64 raw data bits of a burst and decides, beat by beat, whether to send it inverted. It returns the encoded beats, the inversion flags and an 8-bit checksum. The checksum is sent after the last beat and covers the bits as they go out on the wire.

The checksum is not computed on the encoded data. A parallel XOR network first forms a base checksum from the raw, uninverted data, with every flag bit taken as 0. A second stage then folds in one correction term per beat and checksum bit. Each term is chosen by two constant properties and the beat's inversion decision. The first property is whether that beat's flag bit feeds the checksum bit. The second is whether an odd number of that beat's data bits feed it. Both properties are derived from the polynomial during elaboration. This ordering keeps the inversion decision out of the long XOR path.

A two-state machine tracks whether the output register holds a freshly accepted burst. ST_IDLE means no new burst, and ST_LOADED means one was accepted on the previous edge. An edge with `in_valid` high takes either state to ST_LOADED (transition LOAD). An edge with `in_valid` low takes either state to ST_IDLE (transition DRAIN). Reset enters ST_IDLE.

Top module: `ddr_wcrc_top`

## Requirements
- R1: `out_crc` equals a serial checksum over the 72 sent bits. The checksum uses generator x^8+x^2+x+1 (0x07), starts at 0 and shifts MSB first, with feedback = crc[7] XOR input bit. Bits are fed beat 0 first. Within each beat the order is data bit 0 to data bit 7, then that beat's `out_dbi_n` bit.
- R2: A beat is inverted when more than four of its eight raw data bits are 0. Its `out_dbi_n` bit is then 0. Beat k is `in_data[8k+7:8k]` and flag bit k.
- R3: A beat with exactly four zero bits is not inverted, and its `out_dbi_n` bit is 1.
- R4: Each encoded beat in `out_data` is the raw beat, bitwise complemented when that beat is inverted. It keeps the same bit positions.
- R5: `out_valid` is high exactly one cycle after an edge with `in_valid` high. Data, flags and checksum for that burst appear in that same cycle.
- R6: Bursts on consecutive cycles are each accepted, and each produces its own correct output one cycle later.
- R7: After reset, `out_valid` is 0 until a burst is accepted.
- R8: While `in_valid` is low, `out_data`, `out_dbi_n` and `out_crc` keep the values of the last accepted burst.
- R9: An all-zero burst sends all ones with every flag 0. An all-ones burst sends all ones with every flag 1. Both checksums follow R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Burst present on in_data |
| in_data | input | 64 | Raw burst, beat k in bits 8k+7:8k |
| out_valid | output | 1 | Outputs hold a burst accepted on the previous edge |
| out_data | output | 64 | Encoded burst, same beat layout |
| out_dbi_n | output | 8 | Active-low inversion flag per beat |
| out_crc | output | 8 | Checksum over the sent burst |

## Verification
Suppose a per-beat oddness or inclusion constant is wrong. Then the checksum is wrong only for bursts where that beat is inverted, or only where it is not. It shows up at the checksum port in the cycle after such a burst. For that reason the bench mixes all-inverted, never-inverted and exactly-four-zero beats with random ones. Suppose instead the state register or the input register misbehaves. Then `out_valid` or held outputs differ at the very next sample, so a per-cycle comparison catches it immediately.

// File: rtl/ddr_wcrc_pkg.sv
package ddr_wcrc_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } wcrc_state_e;

    // Contribution of a single 1 at stream position pos to checksum bit idx,
    // for an MSB-first shift register starting at zero.
    function automatic logic impulse_bit(int pos, int total, int crc_w, int poly, int idx);
        logic [31:0] s;
        logic [31:0] msk;
        logic        fb;
        msk = (32'd1 << crc_w) - 32'd1;
        s   = poly & msk;
        for (int t = 0; t < total - 1 - pos; t++) begin
            fb = s[crc_w-1];
            s  = (s << 1) & msk;
            if (fb) s = s ^ poly;
        end
        return s[idx];
    endfunction

endpackage

// File: rtl/dbi_beat_enc.sv
module dbi_beat_enc #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] enc,
    output logic         inv
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] zeros;

    always_comb begin
        zeros = '0;
        for (int j = 0; j < W; j++) begin
            if (!raw[j]) zeros = zeros + CW'(1);
        end
        inv = (zeros > CW'(W / 2));
        enc = inv ? ~raw : raw;
    end
endmodule

// File: rtl/crc_base_xor.sv
module crc_base_xor #(
    parameter int BEATS = 8,
    parameter int W     = 8,
    parameter int CRC_W = 8,
    parameter int POLY  = 'h07
) (
    input  logic [BEATS*W-1:0] raw,
    output logic [CRC_W-1:0]   base
);
    import ddr_wcrc_pkg::*;

    localparam int DATA  = BEATS * W;
    localparam int TOTAL = BEATS * (W + 1);

    function automatic logic [DATA-1:0] data_mask(int idx);
        logic [DATA-1:0] m;
        m = '0;
        for (int k = 0; k < BEATS; k++)
            for (int j = 0; j < W; j++)
                m[k*W+j] = impulse_bit(k*(W+1)+j, TOTAL, CRC_W, POLY, idx);
        return m;
    endfunction

    // Flag bits are taken as zero here; crc_dbi_fix adds them back.
    for (genvar i = 0; i < CRC_W; i++) begin : g_bit
        localparam logic [DATA-1:0] MASK = data_mask(i);
        assign base[i] = ^(raw & MASK);
    end
endmodule

// File: rtl/crc_dbi_fix.sv
module crc_dbi_fix #(
    parameter int BEATS = 8,
    parameter int W     = 8,
    parameter int CRC_W = 8,
    parameter int POLY  = 'h07
) (
    input  logic [CRC_W-1:0] base,
    input  logic [BEATS-1:0] inv,
    output logic [CRC_W-1:0] crc
);
    import ddr_wcrc_pkg::*;

    localparam int TOTAL = BEATS * (W + 1);

    function automatic logic beat_odd(int idx, int k);
        logic p;
        p = 1'b0;
        for (int j = 0; j < W; j++)
            p = p ^ impulse_bit(k*(W+1)+j, TOTAL, CRC_W, POLY, idx);
        return p;
    endfunction

    for (genvar i = 0; i < CRC_W; i++) begin : g_bit
        logic [BEATS-1:0] term;
        for (genvar k = 0; k < BEATS; k++) begin : g_beat
            localparam logic INCL = impulse_bit(k*(W+1)+W, TOTAL, CRC_W, POLY, i);
            localparam logic ODD  = beat_odd(i, k);
            // Flag bit sent is ~inv; inverting the beat flips the bit iff ODD.
            assign term[k] = (INCL & ~inv[k]) ^ (ODD & inv[k]);
        end
        // Late merge: one XOR level beyond the base tree.
        assign crc[i] = base[i] ^ (^term);
    end
endmodule

// File: rtl/ddr_wcrc_top.sv
module ddr_wcrc_top #(
    parameter int BEATS = 8,
    parameter int W     = 8,
    parameter int CRC_W = 8,
    parameter int POLY  = 'h07
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [BEATS*W-1:0]   in_data,
    output logic                 out_valid,
    output logic [BEATS*W-1:0]   out_data,
    output logic [BEATS-1:0]     out_dbi_n,
    output logic [CRC_W-1:0]     out_crc
);
    import ddr_wcrc_pkg::*;

    localparam int DATA = BEATS * W;

    wcrc_state_e     state, state_nx;
    logic [DATA-1:0] raw_q;
    logic [BEATS-1:0] inv;
    logic [CRC_W-1:0] base;

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_nx = in_valid ? ST_LOADED : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            raw_q <= '0;
        end else begin
            state <= state_nx;
            if (in_valid) raw_q <= in_data;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   out_valid = 1'b0;
            ST_LOADED: out_valid = 1'b1;
            default:   out_valid = 1'b0;
        endcase
    end

    for (genvar k = 0; k < BEATS; k++) begin : g_enc
        dbi_beat_enc #(.W(W)) u_enc (
            .raw (raw_q[k*W +: W]),
            .enc (out_data[k*W +: W]),
            .inv (inv[k])
        );
    end

    assign out_dbi_n = ~inv;

    crc_base_xor #(.BEATS(BEATS), .W(W), .CRC_W(CRC_W), .POLY(POLY)) u_base (
        .raw  (raw_q),
        .base (base)
    );

    crc_dbi_fix #(.BEATS(BEATS), .W(W), .CRC_W(CRC_W), .POLY(POLY)) u_fix (
        .base (base),
        .inv  (inv),
        .crc  (out_crc)
    );
endmodule

// File: rtl/ddr_wcrc_chk.sv
module ddr_wcrc_chk #(
    parameter int BEATS = 8,
    parameter int W     = 8,
    parameter int CRC_W = 8,
    parameter int POLY  = 'h07
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic [BEATS*W-1:0] out_data,
    input logic [BEATS-1:0]   out_dbi_n,
    input logic [CRC_W-1:0]   out_crc
);
    function automatic logic [CRC_W-1:0] ser_crc(logic [BEATS*W-1:0] d, logic [BEATS-1:0] f);
        logic [CRC_W-1:0] c;
        logic             b;
        logic             fb;
        c = '0;
        for (int k = 0; k < BEATS; k++) begin
            for (int j = 0; j <= W; j++) begin
                b  = (j == W) ? f[k] : d[k*W+j];
                fb = c[CRC_W-1] ^ b;
                c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_W'(POLY) : '0);
            end
        end
        return c;
    endfunction

    p_crc_wire_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_crc == ser_crc(out_data, out_dbi_n)));

    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_dbi_n) && $stable(out_crc)));

    for (genvar k = 0; k < BEATS; k++) begin : g_beat
        p_inv_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_dbi_n[k]) |-> ($countones(out_data[k*W +: W]) > W / 2));
        p_plain_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_dbi_n[k]) |-> ($countones(out_data[k*W +: W]) >= W / 2));
    end
endmodule

bind ddr_wcrc_top ddr_wcrc_chk #(.BEATS(BEATS), .W(W), .CRC_W(CRC_W), .POLY(POLY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_dbi_n (out_dbi_n),
    .out_crc   (out_crc)
);

// File: tb/ddr_wcrc_top_tb_top.sv
module ddr_wcrc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [7:0]  out_dbi_n;
    logic [7:0]  out_crc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        exp_valid = 1'b0;
    logic [63:0] exp_data = '0;
    logic [7:0]  exp_dbi_n = '0;
    logic [7:0]  exp_crc = '0;
    bit          exp_known = 1'b0;
    string       tag = "R7 reset";

    always #2 clk = ~clk;

    ddr_wcrc_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_dbi_n(out_dbi_n), .out_crc(out_crc)
    );

    // Behavioural reference: encode each beat, then checksum the 72-bit stream serially.
    task automatic model(input logic [63:0] raw, output logic [63:0] d,
                         output logic [7:0] f, output logic [7:0] c);
        int z;
        logic fb, b;
        for (int k = 0; k < 8; k++) begin
            z = 0;
            for (int j = 0; j < 8; j++) if (raw[k*8+j] == 1'b0) z++;
            f[k] = (z > 4) ? 1'b0 : 1'b1;
            d[k*8 +: 8] = f[k] ? raw[k*8 +: 8] : ~raw[k*8 +: 8];
        end
        c = 8'h00;
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 9; j++) begin
                b  = (j == 8) ? f[k] : d[k*8+j];
                fb = c[7] ^ b;
                c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
    endtask

    task automatic compare();
        checks++;
        if (out_valid !== exp_valid) begin
            failures++;
            $display("FAIL R5 valid [%s] actual=%b expected=%b", tag, out_valid, exp_valid);
        end
        if (exp_known) begin
            checks++;
            if (out_dbi_n !== exp_dbi_n) begin
                failures++;
                $display("FAIL R2 flags [%s] actual=%h expected=%h", tag, out_dbi_n, exp_dbi_n);
            end
            checks++;
            if (out_data !== exp_data) begin
                failures++;
                $display("FAIL R4 data [%s] actual=%h expected=%h", tag, out_data, exp_data);
            end
            checks++;
            if (out_crc !== exp_crc) begin
                failures++;
                $display("FAIL R1 crc [%s] actual=%h expected=%h", tag, out_crc, exp_crc);
            end
        end
    endtask

    // One cycle: check the state produced by the previous drive, then drive anew.
    task automatic step(input logic v, input logic [63:0] d);
        @(negedge clk);
        compare();
        in_valid = v;
        in_data  = d;
        exp_valid = v;
        if (v) begin
            model(d, exp_data, exp_dbi_n, exp_crc);
            exp_known = 1'b1;
        end
    endtask

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R7 reset valid actual=%b expected=0", out_valid);
        end
        rst_n = 1'b1;
        tag = "R7 idle after reset";
        repeat (3) step(1'b0, 64'h0);

        tag = "R9 all zeros";
        step(1'b1, 64'h0);
        tag = "R9 all ones";
        step(1'b1, {64{1'b1}});
        tag = "R8 hold";
        repeat (3) step(1'b0, 64'hDEAD_BEEF_0123_4567);

        tag = "R3 four zeros";
        step(1'b1, 64'h0F_F0_55_AA_33_CC_69_96);
        step(1'b1, 64'h1E_E1_3C_C3_5A_A5_78_87);
        tag = "R2 five zeros";
        step(1'b1, 64'h07_70_15_A8_31_8C_49_92);
        tag = "R2 mixed four and five";
        step(1'b1, 64'h0F_07_F0_70_55_15_AA_A8);
        step(1'b0, 64'h0);

        tag = "R6 back-to-back random";
        for (int n = 0; n < 300; n++) begin
            r = {$urandom, $urandom};
            step(1'b1, r);
        end
        tag = "R8 random with gaps";
        for (int n = 0; n < 300; n++) begin
            r = {$urandom, $urandom};
            step(($urandom % 3) != 0, r);
        end
        step(1'b0, 64'h0);
        step(1'b0, 64'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule